// File: doc/BRIEF.md
# Infrared Line Sampler with Receive Queue

This block turns the output of an infrared receiver module into bytes that software can read. The receive line first passes through a two-flop synchronizer. It can then be inverted. A programmable divisor sets how often the line is sampled, one sample every DIV clock cycles. The samples are packed most-significant-bit first into bytes. Each finished byte goes into an eight-entry queue.

The block does not decode the carrier or any remote-control protocol. Software reads the raw sample bytes and decodes them. A protocol-select field is stored in a control register and driven out on a port for software and neighbouring logic. A small register port provides the following:

- Queue read: a read removes the oldest byte.
- Queue depth: the number of bytes waiting.
- Queue flush.
- Two status flags: a sticky ready flag and a data-lost flag, both write-1-to-clear.
- Interrupt enable.

Top module: `irx_sampler`

## Requirements
- R1: The queue stores up to 8 bytes and returns them oldest first. A read at address 0 returns the oldest byte combinationally and removes it at the clock edge. A read at address 0 while the queue is empty returns 0x00 and changes nothing.
- R2: The receive line passes through two flops. It is then XORed with the invert bit, and one sample is taken every DIV clock cycles (a DIV of 0 behaves as 1). Samples shift in MSB first, and the eighth sample completes a byte.
- R3: The divisor is 16 bits: the low byte is at address 3 and the high byte at address 4. It resets to 0x01A5. Writing either divisor byte restarts the sample interval and discards any partly assembled byte.
- R4: The status register is at address 2, and its bits [7:4] report the number of bytes queued. Writing 1 to bit 3 empties the queue and clears the ready flag. Bit 3 reads as 0.
- R5: A byte that completes while the queue is full, with no read in the same cycle, is dropped. The dropped byte sets the lost flag (status bit 1) and the queue contents are unchanged.
- R6: The ready flag (status bit 0) is set whenever a byte is stored. Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 has no effect. If a byte is stored in the same cycle as the clear, the ready flag stays set.
- R7: The control register is at address 5. Bit 4 is the invert control and resets to 1. Bits [2:0] are the protocol-select field, which resets to 001 and is driven on `proto_o`. All other bits read as 0.
- R8: The interrupt enable is bit 7 at address 1 and resets to 0. `irq_o` is high exactly while the enable is set and the ready flag or the lost flag is set.
- R9: After reset, the status register reads 0x00 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_line_i | input | 1 | Raw receiver line, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read at address 0 pops the queue) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |
| proto_o | output | 3 | Stored protocol-select field |

## Verification
The assertions check four properties on every cycle:

- The queue depth never exceeds eight.
- A flush leaves the queue empty on the next cycle.
- A dropped byte leaves the depth unchanged and raises the lost flag.
- A stored byte raises the ready flag, and two completed bytes never fall on adjacent cycles.

Only the bench scenarios can show the values of the bytes themselves. These include MSB-first packing through the synchronizer, the effect of the invert bit, the restart caused by writing the divisor under two divisor settings, oldest-first order after an overflow, write-1-to-clear against write-0, and the interrupt tracking its enable and flags.

// File: rtl/irx_pkg.sv
package irx_pkg;
    typedef enum logic [2:0] {
        ADDR_DATA   = 3'd0,
        ADDR_IRQEN  = 3'd1,
        ADDR_STATUS = 3'd2,
        ADDR_DIVLO  = 3'd3,
        ADDR_DIVHI  = 3'd4,
        ADDR_CTRL   = 3'd5
    } irx_addr_e;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_LOST_BIT  = 1;
    localparam int STAT_FLUSH_BIT = 3;
    localparam int CTRL_INV_BIT   = 4;
    localparam int IRQEN_BIT      = 7;
    localparam logic [2:0] PROTO_RESET = 3'b001;
endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/irx_shifter.sv
module irx_shifter #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              restart_i,
    output logic              push_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [BW-1:0]     bits;
        logic [DATA_W-1:0] sh;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic [DIV_W:0] cnt_next;
    logic           tick;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        st_d     = st_q;
        cnt_next = {1'b0, st_q.cnt} + 1'b1;
        tick     = (cnt_next >= {1'b0, div_i});
        shifted  = {st_q.sh[DATA_W-2:0], bit_i};
        push_o   = 1'b0;
        byte_o   = shifted;
        if (restart_i) begin
            st_d = '0;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.sh  = shifted;
            if (st_q.bits == LAST_BIT) begin
                st_d.bits = '0;
                push_o    = 1'b1;
            end else begin
                st_d.bits = st_q.bits + 1'b1;
            end
        end else begin
            st_d.cnt = cnt_next[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PUSH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o); // R2
endmodule

// File: rtl/irx_fifo.sv
module irx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    input  logic          flush_i,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic [W-1:0]  head_o,
    output logic          drop_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.cnt != '0);
        do_push = push_i && ((st_q.cnt != FULL_CNT) || do_pop);
        drop_o  = push_i && !flush_i && !do_push;
        if (flush_i) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = data_i;
                st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
            end
            if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
            else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign head_o  = (st_q.cnt == '0) ? '0 : st_q.mem[st_q.rd];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_o == '0)); // R4
    AST_DROP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> (count_o == $past(count_o))); // R5
endmodule

// File: rtl/irx_sampler.sv
module irx_sampler
    import irx_pkg::*;
#(
    parameter int          DIV_W       = 16,
    parameter int          DATA_W      = 8,
    parameter int          FIFO_DEPTH  = 8,
    parameter logic [15:0] DIV_RESET   = 16'h01A5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_line_i,
    input  logic       reg_wr_i,
    input  logic       reg_rd_i,
    input  logic [2:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq_o,
    output logic [2:0] proto_o
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             inv;
        logic [2:0]       proto;
        logic             irq_en;
        logic             ready;
        logic             lost;
    } regs_t;

    regs_t r_d, r_q;

    logic              line_sync, line_bit;
    logic              push, drop, stored;
    logic [DATA_W-1:0] rx_byte, head;
    logic [CW-1:0]     count;
    logic              wr_status, pop, flush, restart;

    irx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ir_line_i), .sync_o(line_sync)
    );

    assign line_bit = line_sync ^ r_q.inv;

    irx_shifter #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_i(line_bit), .div_i(r_q.div),
        .restart_i(restart), .push_o(push), .byte_o(rx_byte)
    );

    irx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(rx_byte),
        .pop_i(pop), .flush_i(flush), .count_o(count), .head_o(head),
        .drop_o(drop)
    );

    assign wr_status = reg_wr_i && (reg_addr_i == ADDR_STATUS);
    assign pop       = reg_rd_i && (reg_addr_i == ADDR_DATA);
    assign flush     = wr_status && reg_wdata_i[STAT_FLUSH_BIT];
    assign restart   = reg_wr_i && ((reg_addr_i == ADDR_DIVLO) || (reg_addr_i == ADDR_DIVHI));
    assign stored    = push && !drop && !flush;

    always_comb begin
        r_d = r_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                ADDR_IRQEN: r_d.irq_en = reg_wdata_i[IRQEN_BIT];
                ADDR_DIVLO: r_d.div[7:0] = reg_wdata_i;
                ADDR_DIVHI: r_d.div[DIV_W-1:8] = reg_wdata_i[DIV_W-9:0];
                ADDR_CTRL: begin
                    r_d.inv   = reg_wdata_i[CTRL_INV_BIT];
                    r_d.proto = reg_wdata_i[2:0];
                end
                default: ;
            endcase
        end
        if (wr_status && reg_wdata_i[STAT_READY_BIT]) r_d.ready = 1'b0;
        if (wr_status && reg_wdata_i[STAT_LOST_BIT])  r_d.lost  = 1'b0;
        if (stored) r_d.ready = 1'b1;
        if (flush)  r_d.ready = 1'b0;
        if (drop)   r_d.lost  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.div    <= DIV_RESET[DIV_W-1:0];
            r_q.inv    <= 1'b1;
            r_q.proto  <= PROTO_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_DATA:   reg_rdata_o = head;
            ADDR_IRQEN:  reg_rdata_o[IRQEN_BIT] = r_q.irq_en;
            ADDR_STATUS: begin
                reg_rdata_o[7:4] = count[3:0];
                reg_rdata_o[STAT_LOST_BIT]  = r_q.lost;
                reg_rdata_o[STAT_READY_BIT] = r_q.ready;
            end
            ADDR_DIVLO:  reg_rdata_o = r_q.div[7:0];
            ADDR_DIVHI:  reg_rdata_o = r_q.div[DIV_W-1:8];
            ADDR_CTRL: begin
                reg_rdata_o[CTRL_INV_BIT] = r_q.inv;
                reg_rdata_o[2:0] = r_q.proto;
            end
            default: ;
        endcase
    end

    assign irq_o   = r_q.irq_en && (r_q.ready || r_q.lost);
    assign proto_o = r_q.proto;

    AST_DROP_SETS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> r_q.lost); // R5
    AST_STORE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        stored |=> r_q.ready); // R6
endmodule

// File: tb/irx_sampler_test.sv
module irx_sampler_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_line = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic [2:0] proto;

    int checks = 0;
    int errors = 0;
    int div_cyc = 4;
    logic inv = 1'b1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irx_sampler uut (
        .clk(clk), .rst_n(rst_n), .ir_line_i(ir_line),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_o(irq), .proto_o(proto)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic stream_start(input logic first_bit);
        reg_write(3'd2, 8'h0B);
        ir_line = first_bit ^ inv;
        reg_write(3'd3, 8'(div_cyc));
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            ir_line = b[i] ^ inv;
            repeat (div_cyc) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        reg_read(3'd2, d); check("R9 status after reset", d, 8'h00);
        reg_read(3'd1, d); check("R8 irq enable reset", d, 8'h00);
        reg_read(3'd3, d); check("R3 divisor low reset", d, 8'hA5);
        reg_read(3'd4, d); check("R3 divisor high reset", d, 8'h01);
        reg_read(3'd5, d); check("R7 control reset", d, 8'h11);
        check("R7 proto_o reset", {5'b0, proto}, 8'h01);
        check("R8 irq low at reset", {7'b0, irq}, 8'h00);
        reg_read(3'd0, d); check("R1 empty read", d, 8'h00);
    endtask

    task automatic t_single_inverted;
        logic [7:0] d;
        stream_start(1'b1);
        send_byte(8'hA5);
        reg_read(3'd2, d); check("R6 ready with one byte", d, 8'h11);
        reg_read(3'd0, d); check("R2 inverted byte", d, 8'hA5);
        reg_read(3'd2, d); check("R4 count after pop", d, 8'h01);
    endtask

    task automatic t_order_plain;
        logic [7:0] d;
        reg_write(3'd5, 8'h01); inv = 1'b0;
        stream_start(1'b0);
        send_byte(8'h3C); send_byte(8'hC1); send_byte(8'h5E);
        reg_read(3'd2, d); check("R4 count three", d, 8'h31);
        reg_read(3'd0, d); check("R1 order first", d, 8'h3C);
        reg_read(3'd0, d); check("R1 order second", d, 8'hC1);
        reg_read(3'd0, d); check("R1 order third", d, 8'h5E);
        reg_write(3'd5, 8'h11); inv = 1'b1;
    endtask

    task automatic t_overflow_w1c;
        logic [7:0] d;
        stream_start(1'b0);
        for (int k = 0; k < 9; k++) send_byte(8'(8'h10 + k * 8'h11));
        reg_read(3'd2, d); check("R5 full with lost", d, 8'h83);
        for (int k = 0; k < 8; k++) begin
            reg_read(3'd0, d); check("R5 kept bytes in order", d, 8'(8'h10 + k * 8'h11));
        end
        reg_read(3'd0, d); check("R1 ninth byte dropped", d, 8'h00);
        reg_write(3'd2, 8'h00);
        reg_read(3'd2, d); check("R6 write zero no effect", d, 8'h03);
        reg_write(3'd2, 8'h01);
        reg_read(3'd2, d); check("R6 clear ready only", d, 8'h02);
        reg_write(3'd2, 8'h02);
        reg_read(3'd2, d); check("R6 clear lost", d, 8'h00);
    endtask

    task automatic t_flush;
        logic [7:0] d;
        stream_start(1'b1);
        send_byte(8'h81); send_byte(8'h7E);
        reg_read(3'd2, d); check("R4 count two", d, 8'h21);
        reg_write(3'd2, 8'h08);
        reg_read(3'd2, d); check("R4 flush empties and clears ready", d, 8'h00);
        reg_read(3'd0, d); check("R4 data after flush", d, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        stream_start(1'b1);
        send_byte(8'hA1);
        check("R8 irq off while disabled", {7'b0, irq}, 8'h00);
        reg_write(3'd1, 8'h80);
        check("R8 irq on with ready", {7'b0, irq}, 8'h01);
        reg_read(3'd1, d); check("R8 enable readback", d, 8'h80);
        reg_write(3'd2, 8'h01);
        check("R8 irq off after clear", {7'b0, irq}, 8'h00);
        reg_write(3'd1, 8'h00);
    endtask

    task automatic t_divisor;
        logic [7:0] d;
        div_cyc = 3;
        stream_start(1'b1);
        send_byte(8'h96);
        reg_read(3'd2, d); check("R3 one byte at divisor 3", d, 8'h11);
        reg_read(3'd0, d); check("R3 byte at divisor 3", d, 8'h96);
        reg_read(3'd3, d); check("R3 divisor low readback", d, 8'h03);
        // restart mid-byte: partial samples must be discarded
        stream_start(1'b1);
        send_byte(8'hF0);
        ir_line = 1'b0 ^ inv;
        repeat (3 * div_cyc) @(negedge clk);
        reg_write(3'd2, 8'h0B);
        stream_start(1'b0);
        send_byte(8'h0F);
        reg_read(3'd0, d); check("R3 restart discards partial", d, 8'h0F);
        div_cyc = 4;
    endtask

    task automatic t_ctrl;
        logic [7:0] d;
        reg_write(3'd5, 8'h15);
        check("R7 proto_o follows", {5'b0, proto}, 8'h05);
        reg_write(3'd5, 8'hFF);
        reg_read(3'd5, d); check("R7 unused bits read zero", d, 8'h17);
        reg_write(3'd5, 8'h11);
    endtask

    initial begin
        repeat (CLK_PERIOD * 1000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        reg_write(3'd4, 8'h00);
        t_single_inverted();
        t_order_plain();
        t_overflow_w1c();
        t_flush();
        t_irq();
        t_divisor();
        t_ctrl();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule